// File: doc/BRIEF.md
# Keyed Power-Management Control Register

This block holds one 8-bit control register on a simple synchronous register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. The register selects a CPU vendor mode and turns on three things: a reset-out pin, on-the-fly voltage-ID changes and an extended voltage-ID mode. It also lets software command a full software reset and an immediate power-down. The voltage-ID bits and the vendor select are protected in two ways. They take a write only after software has written a magic byte to a separate key register. An active-low slot-occupied input forces them back to zero.

Power management has two sources. The first is a soft power-down bit, which stops the clock and turns off the analog blocks at once. It clears when software writes it to 0 or when any GPIO input changes state. The second is an optional idle timer, which drops the block into automatic power-down after a programmable number of quiet cycles (20 ms at the configured clock). Any bus access or GPIO change wakes the block from this state. GPIO inputs pass through a two-flop synchroniser before edge detection. The analog circuits, the real clock gate and the voltage-ID logic are outside this block; it only drives their enables.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset, a read of the control register (address 0x01) returns 0x08 and a read of the key register (address 0x30) returns 0x00.
- R2: Writing control data with bit 7 set returns every register to its reset value at that clock edge, and the key relocks. The other bits of that write are discarded, and bit 7 always reads 0.
- R3: Bit 2 of the control register is reserved. It always reads 0, and writes to it have no effect.
- R4: Bits 6 (CPU select), 4 (on-the-fly enable) and 3 (extended voltage-ID) change on a write only while the key is open. Writing 0xA5 to 0x30 opens the key, and any other value written there closes it. A key read returns bit 0 = 1 while the key is open. Bits 5, 1 and 0 are always writable.
- R5: While slot_occ_ni is low, bits 6, 4 and 3 are cleared from the next edge onward and the key is closed. This takes priority over any write.
- R6: rst_out_o equals rst_src_i when control bit 5 is 1, and is 0 when bit 5 is 0.
- R7: Writing bit 0 = 1 asserts clk_stop_o and analog_off_o from the next edge, and writing bit 0 = 0 releases them.
- R8: A state change on any GPIO input clears bit 0 within three clock edges, unless a control write lands in the same cycle.
- R9: With bit 1 set and no activity, auto_pd_o rises exactly IDLE_CYCLES edges after the edge that set bit 1, and clk_stop_o and analog_off_o follow it.
- R10: While auto_pd_o is high, any bus read or write at any address, or any GPIO change, clears auto_pd_o.
- R11: cpu_sel_o, otf_en_o and vid_ext_o reflect control bits 6, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when rd_i is low |
| slot_occ_ni | input | 1 | Slot occupied, active low |
| gpio_i | input | GPIO_W | GPIO levels used as wake sources |
| rst_src_i | input | 1 | Reset request forwarded to the reset-out pin |
| rst_out_o | output | 1 | Gated reset-out pin |
| cpu_sel_o | output | 1 | CPU vendor select |
| otf_en_o | output | 1 | On-the-fly voltage-ID enable |
| vid_ext_o | output | 1 | Extended voltage-ID mode |
| clk_stop_o | output | 1 | Clock stop request |
| analog_off_o | output | 1 | Analog power-off request |
| auto_pd_o | output | 1 | Automatic power-down active |

## Verification
The table walk writes the protected bits with the key closed, then open, then closed again, and sets the reserved bit each time. A design that gated the wrong mask, or stored bit 2, would read back a value that differs from the expected byte. Directed tests check the software reset, slot-occupied assertion and the reset-out gate. They also time the idle timeout to the exact edge, so an off-by-one counter is caught on one side or the other. Finally they check wake-up by a bus read and by a GPIO toggle; a design that missed either source would leave auto_pd_o or clk_stop_o high.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h01;
  localparam logic [7:0] ADDR_KEY  = 8'h30;
  localparam logic [7:0] KEY_MAGIC = 8'hA5;

  localparam int B_SWRST  = 7;
  localparam int B_CPU    = 6;
  localparam int B_RSTOUT = 5;
  localparam int B_OTF    = 4;
  localparam int B_VIDX   = 3;
  localparam int B_RSV    = 2;
  localparam int B_AUTO   = 1;
  localparam int B_SOFT   = 0;

  typedef struct packed {
    logic cpu_sel;
    logic rst_out_en;
    logic otf_en;
    logic vid_ext;
    logic auto_en;
    logic soft_pd;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{cpu_sel: 1'b0, rst_out_en: 1'b0, otf_en: 1'b0,
                                     vid_ext: 1'b1, auto_en: 1'b0, soft_pd: 1'b0};

  function automatic logic [7:0] ctrl_pack(ctrl_t c);
    logic [7:0] v;
    v = '0;
    v[B_CPU]    = c.cpu_sel;
    v[B_RSTOUT] = c.rst_out_en;
    v[B_OTF]    = c.otf_en;
    v[B_VIDX]   = c.vid_ext;
    v[B_AUTO]   = c.auto_en;
    v[B_SOFT]   = c.soft_pd;
    return v;
  endfunction
endpackage

// File: rtl/pmc_gpio_sync.sv
module pmc_gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gpio_i,
  output logic         change_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= gpio_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign edge_w[i] = sync_q[i] ^ prev_q[i];
  end

  assign change_o = |edge_w;
endmodule

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int IDLE_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic activity_i,
  output logic asleep_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          asleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (!en_i || activity_i) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (!asleep_q) begin
      if (cnt_q == LAST) begin
        cnt_q    <= '0;
        asleep_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign asleep_o = asleep_q;
endmodule

// File: rtl/pmc_key_reg.sv
module pmc_key_reg
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_key_i,
  input  logic [7:0] wdata_i,
  input  logic       relock_i,
  output logic       open_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (relock_i) open_q <= 1'b0;
    else if (wr_key_i) open_q <= (wdata_i == KEY_MAGIC);
  end

  assign open_o = open_q;
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic [7:0] wdata_i,
  input  logic       swrst_i,
  input  logic       key_open_i,
  input  logic       slot_clr_i,
  input  logic       gpio_change_i,
  output ctrl_t      ctrl_o
);
  ctrl_t q, d;

  always_comb begin
    d = q;
    if (swrst_i) begin
      d = CTRL_DEFAULT;
    end else begin
      if (wr_ctrl_i) begin
        d.rst_out_en = wdata_i[B_RSTOUT];
        d.auto_en    = wdata_i[B_AUTO];
        d.soft_pd    = wdata_i[B_SOFT];
        if (key_open_i) begin
          d.cpu_sel = wdata_i[B_CPU];
          d.otf_en  = wdata_i[B_OTF];
          d.vid_ext = wdata_i[B_VIDX];
        end
      end else if (gpio_change_i) begin
        d.soft_pd = 1'b0;
      end
    end
    if (slot_clr_i) begin
      d.cpu_sel = 1'b0;
      d.otf_en  = 1'b0;
      d.vid_ext = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CTRL_DEFAULT;
    else         q <= d;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int GPIO_W  = 16,
  parameter int CLK_KHZ = 1000,
  parameter int IDLE_MS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              slot_occ_ni,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              rst_src_i,
  output logic              rst_out_o,
  output logic              cpu_sel_o,
  output logic              otf_en_o,
  output logic              vid_ext_o,
  output logic              clk_stop_o,
  output logic              analog_off_o,
  output logic              auto_pd_o
);
  localparam int IDLE_CYCLES = CLK_KHZ * IDLE_MS;

  logic  wr_ctrl, wr_key, swrst, key_open, gpio_change, auto_pd, bus_act;
  logic  rst_out_en;
  ctrl_t ctrl;
  logic  unused_rsv;

  assign wr_ctrl    = wr_i && (addr_i == ADDR_CTRL);
  assign wr_key     = wr_i && (addr_i == ADDR_KEY);
  assign swrst      = wr_ctrl && wdata_i[B_SWRST];
  assign bus_act    = wr_i || rd_i;
  assign unused_rsv = wdata_i[B_RSV];

  pmc_gpio_sync #(.W(GPIO_W)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gpio_i   (gpio_i),
    .change_o (gpio_change)
  );

  pmc_key_reg u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_key_i (wr_key),
    .wdata_i  (wdata_i),
    .relock_i (swrst || !slot_occ_ni),
    .open_o   (key_open)
  );

  pmc_ctrl_reg u_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_ctrl_i     (wr_ctrl),
    .wdata_i       (wdata_i),
    .swrst_i       (swrst),
    .key_open_i    (key_open),
    .slot_clr_i    (!slot_occ_ni),
    .gpio_change_i (gpio_change),
    .ctrl_o        (ctrl)
  );

  pmc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.auto_en),
    .activity_i (bus_act || gpio_change),
    .asleep_o   (auto_pd)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_CTRL: rdata_o = ctrl_pack(ctrl);
        ADDR_KEY:  rdata_o = {7'b0, key_open};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign rst_out_en   = ctrl.rst_out_en;
  assign rst_out_o    = rst_out_en && rst_src_i;
  assign cpu_sel_o    = ctrl.cpu_sel;
  assign otf_en_o     = ctrl.otf_en;
  assign vid_ext_o    = ctrl.vid_ext;
  assign auto_pd_o    = auto_pd;
  assign clk_stop_o   = ctrl.soft_pd || auto_pd;
  assign analog_off_o = ctrl.soft_pd || auto_pd;
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       slot_occ_ni,
  input logic       rst_out_o,
  input logic       cpu_sel_o,
  input logic       otf_en_o,
  input logic       vid_ext_o,
  input logic       clk_stop_o,
  input logic       auto_pd_o,
  input logic       key_open,
  input logic       gpio_change,
  input logic       rst_out_en
);
  a_r3_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h01) |-> (rdata_o[2] == 1'b0 && rdata_o[7] == 1'b0));

  a_r2_swrst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h01 && wdata_i[7]) |=> (!rst_out_en && !key_open && !cpu_sel_o && !otf_en_o));

  a_r4_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h01 && !wdata_i[7] && !key_open && slot_occ_ni)
      |=> ($stable(cpu_sel_o) && $stable(otf_en_o) && $stable(vid_ext_o)));

  a_r5_slot_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_occ_ni |=> (!cpu_sel_o && !otf_en_o && !vid_ext_o && !key_open));

  a_r6_rstout_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_out_en |-> !rst_out_o);

  a_r7_soft_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h01 && wdata_i[0] && !wdata_i[7]) |=> clk_stop_o);

  a_r10_bus_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |=> !auto_pd_o);

  a_r10_gpio_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_change |=> !auto_pd_o);
endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .slot_occ_ni (slot_occ_ni),
  .rst_out_o   (rst_out_o),
  .cpu_sel_o   (cpu_sel_o),
  .otf_en_o    (otf_en_o),
  .vid_ext_o   (vid_ext_o),
  .clk_stop_o  (clk_stop_o),
  .auto_pd_o   (auto_pd_o),
  .key_open    (key_open),
  .gpio_change (gpio_change),
  .rst_out_en  (rst_out_en)
);

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 4;
  localparam int IDLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic slot_n = 1'b1;
  logic [GW-1:0] gpio = '0;
  logic rst_src = 1'b0;
  logic rst_out, cpu_sel, otf_en, vid_ext, clk_stop, analog_off, auto_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_ctrl #(.GPIO_W(GW), .CLK_KHZ(1), .IDLE_MS(IDLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .slot_occ_ni(slot_n), .gpio_i(gpio),
    .rst_src_i(rst_src), .rst_out_o(rst_out), .cpu_sel_o(cpu_sel),
    .otf_en_o(otf_en), .vid_ext_o(vid_ext), .clk_stop_o(clk_stop),
    .analog_off_o(analog_off), .auto_pd_o(auto_pd)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h00, 8'h08},   // R1
    {1'b0, 8'h30, 8'h00, 8'h00},   // R1
    {1'b1, 8'h01, 8'h7C, 8'h00},   // R4 locked, R3 rsv
    {1'b0, 8'h01, 8'h00, 8'h28},
    {1'b1, 8'h30, 8'hA5, 8'h00},   // unlock
    {1'b0, 8'h30, 8'h00, 8'h01},
    {1'b1, 8'h01, 8'h54, 8'h00},   // R4 open
    {1'b0, 8'h01, 8'h00, 8'h50},
    {1'b1, 8'h30, 8'h00, 8'h00},   // relock
    {1'b0, 8'h30, 8'h00, 8'h00},
    {1'b1, 8'h01, 8'h0C, 8'h00},   // R4 locked again
    {1'b0, 8'h01, 8'h00, 8'h50}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 vid_ext_o", {7'b0, vid_ext}, 8'h01);
    chk("R1 clk_stop_o", {7'b0, clk_stop}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) bus_wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][23:16], v);
        chk("R3/R4 table", v, VEC[i][7:0]);
      end
    end
    chk("R11 cpu_sel_o", {7'b0, cpu_sel}, 8'h01);
    chk("R11 otf_en_o", {7'b0, otf_en}, 8'h01);

    // R2 software reset
    bus_wr(8'h30, 8'hA5);
    bus_wr(8'h01, 8'h70);
    bus_wr(8'h01, 8'hFF);
    bus_rd(8'h01, v); chk("R2 ctrl default", v, 8'h08);
    bus_rd(8'h30, v); chk("R2 key relocked", v, 8'h00);

    // R5 slot-occupied clear
    bus_wr(8'h30, 8'hA5);
    bus_wr(8'h01, 8'h58);
    bus_rd(8'h01, v); chk("R5 pre", v, 8'h58);
    @(negedge clk); slot_n = 1'b0;
    @(negedge clk);
    chk("R5 outputs", {5'b0, cpu_sel, otf_en, vid_ext}, 8'h00);
    bus_wr(8'h01, 8'h58);
    slot_n = 1'b1;
    bus_rd(8'h01, v); chk("R5 cleared", v, 8'h00);
    bus_rd(8'h30, v); chk("R5 key closed", v, 8'h00);

    // R6 reset-out gate
    rst_src = 1'b1;
    @(negedge clk); chk("R6 gated off", {7'b0, rst_out}, 8'h00);
    bus_wr(8'h01, 8'h20);
    chk("R6 enabled", {7'b0, rst_out}, 8'h01);
    rst_src = 1'b0;
    #1 chk("R6 follows src", {7'b0, rst_out}, 8'h00);

    // R7 soft power-down
    bus_wr(8'h01, 8'h01);
    chk("R7 pd on", {6'b0, clk_stop, analog_off}, 8'h03);
    bus_wr(8'h01, 8'h00);
    chk("R7 pd off", {6'b0, clk_stop, analog_off}, 8'h00);

    // R8 GPIO clears soft power-down
    bus_wr(8'h01, 8'h01);
    gpio[2] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 clk_stop_o", {7'b0, clk_stop}, 8'h00);
    bus_rd(8'h01, v); chk("R8 bit0", v, 8'h00);

    // R9 idle timeout, exact edge
    bus_wr(8'h01, 8'h02);
    repeat (IDLE - 1) @(negedge clk);
    chk("R9 not yet", {7'b0, auto_pd}, 8'h00);
    @(negedge clk);
    chk("R9 asleep", {6'b0, auto_pd, clk_stop}, 8'h03);

    // R10 bus wake
    bus_rd(8'h55, v);
    chk("R10 bus wake", {6'b0, auto_pd, clk_stop}, 8'h00);

    // R10 GPIO wake
    repeat (IDLE + 2) @(negedge clk);
    chk("R9 asleep again", {7'b0, auto_pd}, 8'h01);
    gpio[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 gpio wake", {7'b0, auto_pd}, 8'h00);

    finish_run();
  end
endmodule